// File: doc/BRIEF.md
# Reconfigurable Multilevel Leg Gate Generator

This block drives the eight series switches of one diode-clamped inverter leg. Each cycle it compares a signed reference sample against a set of signed carrier samples and turns the result into eight gate commands. The lower four gates are always the complements of the upper four. A level-select input tells the block how many output levels the leg should produce. For three-level or two-level operation the upper switches are ganged into groups that fire together, so one five-level power stage can be run as a lower-level stage.

Between the upper gate and the lower gate of each complementary pair, the block inserts a programmable blanking interval: after a pair's command changes, both members stay off for a set number of cycles before the incoming gate turns on. The block also reports the signed switching function of the commanded state. A three-phase drive uses one instance per phase. All phases share the same carriers, and their references are 120 and 240 electrical degrees apart.

Top module: `ml_gate_gen`

## Requirements
- R1: `gate[k-1]` drives switch k (k = 1..8, switch 1 at the positive rail). In steady state `gate[j+4]` equals the inverse of `gate[j]` for j = 0..3. For example, switch pattern 11110000 (switches 1..8) appears as `gate = 8'h0F`.
- R2: With `level_sel = 5`, upper gate j is on exactly when the signed reference is greater than or equal to carrier slot j (`carriers[12*j +: 12]`, slot 0 the highest). Equality counts as on. With descending carriers this gives the five patterns 0F, 1E, 3C, 78 and F0.
- R3: With `level_sel = 3`, gates 0 and 1 both follow the comparison against slot 0, and gates 2 and 3 both follow slot 1. Slots 2 and 3 have no effect.
- R4: With `level_sel = 2`, all four upper gates follow the comparison against slot 0. Slots 1 to 3 have no effect.
- R5: A target level M is legal only when 2 <= M <= 5 and 4 is divisible by M-1, so only 2, 3 and 5 are legal. An illegal selection forces all gates to 0 and sets `mode_err`. A legal selection clears `mode_err`. Both take effect one cycle after the selection is sampled.
- R6: When `enable` is low, all eight gates are 0 and `sw_func` is 0 from the next cycle onward.
- R7: `sw_func` is a signed 3-bit value, registered one cycle after sampling. In five-level mode it equals the number of upper gates on minus 2. In three-level mode it is +1, 0 or -1 (number of groups on minus 1). In two-level mode it is +1 or -1.
- R8: When a pair's command changes, both gates of that pair stay off for exactly D cycles (D = `dead_time`) before the incoming gate turns on. When D = 0 the switchover happens without any off cycle. Other pairs are not disturbed.
- R9: When the block leaves the forced-off state, the gates stay off for D cycles before the commanded pattern appears.
- R10: During reset all gates, `sw_func` and `mode_err` are 0.
- R11: The two gates of a complementary pair are never on at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| enable | input | 1 | When high, gating is allowed; when low, all gates are forced off |
| level_sel | input | 3 | Target level count M |
| ref_sample | input | 12 | Signed reference sample |
| carriers | input | 48 | Four signed carrier samples; slot 0 in the low bits is the highest carrier |
| dead_time | input | 8 | Blanking length in cycles |
| gate | output | 8 | Gate commands for switches 1..8 |
| sw_func | output | 3 | Signed switching function of the commanded state |
| mode_err | output | 1 | Illegal level selection |

## Verification
The bench builds the block with its default parameters: a five-level leg, 12-bit samples and an 8-bit dead-time field. These defaults cover all three legal groupings plus the illegal fourth selection (4 is not divisible by 3), as well as out-of-range codes 0, 1 and 7. Carriers of 12 bits leave room to place the reference exactly on a carrier, which checks the equality case. They also leave room for extreme values in unused carrier slots, which shows that those slots have no effect. The 8-bit dead-time field is tested at 0 and at 3. This measures the exact blanking window on a switchover and after re-enabling.

// File: rtl/mlgg_pkg.sv
package mlgg_pkg;

  // A target level count is usable when it fits the leg and the groups divide evenly.
  function automatic logic level_ok(input int unsigned tgt, input int unsigned avail);
    if (tgt < 2 || tgt > avail) return 1'b0;
    return ((avail - 1) % (tgt - 1)) == 0;
  endfunction

  // Number of series switches fired together for a target level count.
  function automatic int unsigned gang_size(input int unsigned tgt, input int unsigned avail);
    if (tgt < 2 || tgt > avail) return 1;
    return (avail - 1) / (tgt - 1);
  endfunction

endpackage

// File: rtl/mlgg_mode_dec.sv
module mlgg_mode_dec #(
  parameter int LEVELS = 5,
  parameter int SEL_W  = 3,
  parameter int GANG_W = 3
) (
  input  logic [SEL_W-1:0]  level_sel,
  output logic              legal,
  output logic [GANG_W-1:0] gang
);
  int unsigned sel_i;
  int unsigned gang_i;

  always_comb begin
    sel_i  = int'(level_sel);
    legal  = mlgg_pkg::level_ok(sel_i, LEVELS);
    gang_i = mlgg_pkg::gang_size(sel_i, LEVELS);
    gang   = GANG_W'(gang_i);
  end
endmodule

// File: rtl/mlgg_compare.sv
module mlgg_compare #(
  parameter int N_CARR = 4,
  parameter int SMP_W  = 12,
  parameter int SEL_W  = 3,
  parameter int GANG_W = 3,
  parameter int SF_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    legal,
  input  logic [GANG_W-1:0]       gang,
  input  logic [SEL_W-1:0]        level_sel,
  input  logic signed [SMP_W-1:0] ref_sample,
  input  logic [N_CARR*SMP_W-1:0] carriers,
  output logic [N_CARR-1:0]       cmd_q,
  output logic                    off_q,
  output logic                    err_q,
  output logic signed [SF_W-1:0]  sw_q
);
  logic [N_CARR-1:0]      cmp;
  logic [N_CARR-1:0]      cmd_n;
  logic                   off_n;
  logic                   err_n;
  logic signed [SF_W-1:0] sw_n;
  int                     g_i;
  int                     groups_i;
  int                     on_i;
  int                     sw_i;

  genvar k;
  generate
    for (k = 0; k < N_CARR; k++) begin : g_cmp
      assign cmp[k] = ref_sample >= $signed(carriers[k*SMP_W +: SMP_W]);
    end
  endgenerate

  always_comb begin
    g_i      = (gang == '0) ? 1 : int'(gang);
    groups_i = N_CARR / g_i;
    on_i     = 0;
    cmd_n    = '0;
    for (int j = 0; j < N_CARR; j++) begin
      cmd_n[j] = cmp[j / g_i];
    end
    for (int c = 0; c < N_CARR; c++) begin
      if (c < groups_i && cmp[c]) on_i = on_i + 1;
    end
    if (int'(level_sel) == 2) sw_i = cmp[0] ? 1 : -1;
    else                      sw_i = on_i - groups_i / 2;
    off_n = !enable || !legal;
    err_n = !legal;
    sw_n  = off_n ? '0 : SF_W'(sw_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      off_q <= 1'b1;
      err_q <= 1'b0;
      sw_q  <= '0;
    end else begin
      cmd_q <= cmd_n;
      off_q <= off_n;
      err_q <= err_n;
      sw_q  <= sw_n;
    end
  end
endmodule

// File: rtl/mlgg_dt_pair.sv
module mlgg_dt_pair #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            force_off,
  input  logic            cmd,
  input  logic [DT_W-1:0] dead_time,
  output logic            gate_hi,
  output logic            gate_lo
);
  logic            cur_q, cur_n;
  logic [DT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cur_n = cur_q;
    cnt_n = cnt_q;
    if (force_off || (cmd != cur_q)) begin
      cur_n = cmd;
      cnt_n = dead_time;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      cur_q <= cur_n;
      cnt_q <= cnt_n;
    end
  end

  assign gate_hi = !force_off && (cnt_q == '0) &&  cur_q;
  assign gate_lo = !force_off && (cnt_q == '0) && !cur_q;
endmodule

// File: rtl/ml_gate_gen.sv
module ml_gate_gen #(
  parameter int LEVELS = 5,
  parameter int SMP_W  = 12,
  parameter int DT_W   = 8,
  parameter int SEL_W  = 3,
  localparam int N_CARR = LEVELS - 1,
  localparam int N_GATE = 2 * N_CARR,
  localparam int GANG_W = $clog2(N_CARR + 1),
  localparam int SF_W   = $clog2(N_CARR / 2 + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [SEL_W-1:0]        level_sel,
  input  logic signed [SMP_W-1:0] ref_sample,
  input  logic [N_CARR*SMP_W-1:0] carriers,
  input  logic [DT_W-1:0]         dead_time,
  output logic [N_GATE-1:0]       gate,
  output logic signed [SF_W-1:0]  sw_func,
  output logic                    mode_err
);
  logic [1:0]          rst_sync_q;
  logic                rst_sync_n;
  logic                legal;
  logic [GANG_W-1:0]   gang;
  logic [N_CARR-1:0]   cmd_q;
  logic                off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  mlgg_mode_dec #(.LEVELS(LEVELS), .SEL_W(SEL_W), .GANG_W(GANG_W)) mode_i (
    .level_sel (level_sel),
    .legal     (legal),
    .gang      (gang)
  );

  mlgg_compare #(
    .N_CARR(N_CARR), .SMP_W(SMP_W), .SEL_W(SEL_W), .GANG_W(GANG_W), .SF_W(SF_W)
  ) cmp_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .enable     (enable),
    .legal      (legal),
    .gang       (gang),
    .level_sel  (level_sel),
    .ref_sample (ref_sample),
    .carriers   (carriers),
    .cmd_q      (cmd_q),
    .off_q      (off_q),
    .err_q      (mode_err),
    .sw_q       (sw_func)
  );

  genvar p;
  generate
    for (p = 0; p < N_CARR; p++) begin : g_pair
      mlgg_dt_pair #(.DT_W(DT_W)) pair_i (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .force_off (off_q),
        .cmd       (cmd_q[p]),
        .dead_time (dead_time),
        .gate_hi   (gate[p]),
        .gate_lo   (gate[p+N_CARR])
      );
    end
  endgenerate
endmodule

// File: rtl/ml_gate_gen_chk.sv
module ml_gate_gen_chk #(
  parameter int LEVELS = 5,
  parameter int DT_W   = 8,
  parameter int SEL_W  = 3,
  localparam int N_CARR = LEVELS - 1,
  localparam int N_GATE = 2 * N_CARR,
  localparam int SF_W   = $clog2(N_CARR / 2 + 1) + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   enable,
  input logic [SEL_W-1:0]       level_sel,
  input logic [DT_W-1:0]        dead_time,
  input logic [N_GATE-1:0]      gate,
  input logic signed [SF_W-1:0] sw_func,
  input logic                   mode_err
);
  logic sel_legal;
  assign sel_legal = mlgg_pkg::level_ok(int'(level_sel), LEVELS);

  a_r6_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (gate == '0) && (sw_func == '0));

  a_r5_illegal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_legal |=> (gate == '0) && mode_err);

  a_r5_legal_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sel_legal |=> !mode_err);

  a_r7_grouped_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level_sel) != LEVELS) |=> (sw_func >= -1) && (sw_func <= 1));

  genvar j;
  generate
    for (j = 0; j < N_CARR; j++) begin : g_pair_chk
      a_r11_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate[j] && gate[j+N_CARR]));
      a_r8_blank_before_hi: assert property (@(posedge clk) disable iff (!rst_n)
        ((dead_time != '0) && $rose(gate[j])) |-> !$past(gate[j+N_CARR]));
      a_r8_blank_before_lo: assert property (@(posedge clk) disable iff (!rst_n)
        ((dead_time != '0) && $rose(gate[j+N_CARR])) |-> !$past(gate[j]));
    end
  endgenerate
endmodule

bind ml_gate_gen ml_gate_gen_chk #(.LEVELS(LEVELS), .DT_W(DT_W), .SEL_W(SEL_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .enable    (enable),
  .level_sel (level_sel),
  .dead_time (dead_time),
  .gate      (gate),
  .sw_func   (sw_func),
  .mode_err  (mode_err)
);

// File: tb/ml_gate_gen_tb_top.sv
module ml_gate_gen_tb_top;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               enable;
  logic [2:0]         level_sel;
  logic signed [11:0] ref_sample;
  logic [47:0]        carriers;
  logic [7:0]         dead_time;
  logic [7:0]         gate;
  logic signed [2:0]  sw_func;
  logic               mode_err;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  ml_gate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .level_sel(level_sel),
    .ref_sample(ref_sample), .carriers(carriers), .dead_time(dead_time),
    .gate(gate), .sw_func(sw_func), .mode_err(mode_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_carr(input int c0, input int c1, input int c2, input int c3);
    carriers = {12'(c3), 12'(c2), 12'(c1), 12'(c0)};
  endtask

  task automatic settle();
    repeat (int'(dead_time) + 6) @(negedge clk);
  endtask

  task automatic apply(input int r, input logic [7:0] eg, input int es, input string req);
    @(negedge clk);
    ref_sample = 12'(r);
    settle();
    check(gate == eg, req, gate, eg);
    check(int'(sw_func) == es, {req, "/R7"}, int'(sw_func), es);
    check(gate[7:4] == ~gate[3:0], "R1", gate, {~gate[3:0], gate[3:0]});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b1; level_sel = 3'd5; ref_sample = '0;
    dead_time = 8'd2; set_carr(300, 100, -100, -300);
    repeat (4) @(negedge clk);
    check(gate == 8'h00, "R10 gates", gate, 0);
    check(sw_func == 3'sd0, "R10 sw", sw_func, 0);
    check(mode_err == 1'b0, "R10 err", mode_err, 0);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic t_five();
    level_sel = 3'd5; set_carr(300, 100, -100, -300);
    apply(400, 8'h0F, 2, "R2 +2");
    apply(200, 8'h1E, 1, "R2 +1");
    apply(0, 8'h3C, 0, "R2 0");
    apply(-200, 8'h78, -1, "R2 -1");
    apply(-400, 8'hF0, -2, "R2 -2");
    apply(300, 8'h0F, 2, "R2 equal");
  endtask

  task automatic t_three();
    level_sel = 3'd3; set_carr(200, -200, 2000, -2000);
    apply(400, 8'h0F, 1, "R3 +1");
    apply(0, 8'h3C, 0, "R3 0");
    apply(-400, 8'hF0, -1, "R3 -1");
    apply(-200, 8'h3C, 0, "R3 equal");
  endtask

  task automatic t_two();
    level_sel = 3'd2; set_carr(0, 2000, 2000, -2000);
    apply(50, 8'h0F, 1, "R4 +1");
    apply(-50, 8'hF0, -1, "R4 -1");
    apply(0, 8'h0F, 1, "R4 equal");
  endtask

  task automatic t_illegal();
    ref_sample = 12'sd50;
    foreach (level_sel_codes[i]) begin
      @(negedge clk);
      level_sel = level_sel_codes[i];
      @(negedge clk);
      check(gate == 8'h00, "R5 gates off", gate, 0);
      check(mode_err == 1'b1, "R5 err set", mode_err, 1);
    end
    @(negedge clk);
    level_sel = 3'd2;
    @(negedge clk);
    check(mode_err == 1'b0, "R5 err clear", mode_err, 0);
    settle();
    check(gate == 8'h0F, "R5 recover", gate, 8'h0F);
  endtask

  logic [2:0] level_sel_codes [4] = '{3'd4, 3'd0, 3'd1, 3'd7};

  task automatic t_disable();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(gate == 8'h00, "R6 gates", gate, 0);
    check(sw_func == 3'sd0, "R6 sw", sw_func, 0);
    repeat (5) @(negedge clk);
    check(gate == 8'h00, "R6 hold", gate, 0);
  endtask

  task automatic t_reenable(input int d);
    int off_cnt;
    dead_time = 8'(d);
    repeat (3) @(negedge clk);
    enable = 1'b1;
    off_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (gate != 8'h00) break;
      off_cnt++;
    end
    check(off_cnt == d, "R9 blank on resume", off_cnt, d);
    check(gate == 8'h0F, "R9 pattern", gate, 8'h0F);
  endtask

  task automatic t_deadtime(input int d);
    int off_cnt;
    bit other_ok;
    level_sel = 3'd5; set_carr(300, 100, -100, -300);
    dead_time = 8'(d);
    apply(400, 8'h0F, 2, "R8 setup");
    @(negedge clk);
    ref_sample = 12'sd200;
    off_cnt = 0; other_ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (gate[3:1] != 3'b111 || gate[7:5] != 3'b000) other_ok = 1'b0;
      if (gate[4]) break;
      if (!gate[0]) off_cnt++;
    end
    check(off_cnt == d, "R8 blank length", off_cnt, d);
    check(other_ok, "R8 other pairs", gate, 8'h1E);
    check(gate == 8'h1E, "R8 final", gate, 8'h1E);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_five();
    t_three();
    t_two();
    t_illegal();
    t_disable();
    level_sel = 3'd2; ref_sample = 12'sd50;
    t_reenable(3);
    t_disable();
    t_reenable(0);
    t_deadtime(3);
    t_deadtime(0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule